// File: doc/BRIEF.md
# Discrete I/O Edge Interrupt Controller

This block gives software control of eight general-purpose output pins and eight general-purpose input pins through three 32-bit registers on a simple synchronous register port. Each input goes through a two-flop synchroniser and then a digital glitch filter. The filter accepts a new level only after it has been held for a set number of clock cycles. Three cycles at 33 MHz gives roughly 90 ns. The filtered level drives a rising-edge detector and a falling-edge detector. Each detector has its own enable bit and its own sticky status flag, and a flag is cleared by writing a one to it.

The block also brings in the active-low interrupt lines of two external bus controllers. It merges them with its own edge interrupt to form one active-low interrupt output. A third register drives an active-low reset to those controllers.

Register offsets, as the word index on `bus_addr`:
- 0 is the I/O register.
- 1 is the edge control and status register.
- 2 is the controller reset register.
- 3 is unmapped.

Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_sel` and `bus_we` are both high.

Top module: `dio_edge_irq_ctrl`

## Requirements
- R1: After reset, the I/O register reads 0xFF0001FF when both controller interrupts are inactive and the inputs are low. The edge register reads 0. The controller reset register reads 1. `usr_drv_low` is 0, `ctl_rst_n` is 1 and `irq_n` is 1.
- R2: After synchronisation, an input level change is accepted only once it has held for FILT_CYC (3) consecutive clock cycles. A pulse that lasts 2 cycles at the pin changes neither the level readback nor any edge flag. A pulse that lasts 3 cycles is accepted.
- R3: I/O register bits 23..16 read the filtered levels of inputs 7..0.
- R4: In the edge register, bits 7..0 are the rising-edge flags of inputs 7..0 and bits 15..8 are the falling-edge flags. A flag is set by an accepted edge of its kind while its enable bit is high. Rising enables are bits 23..16 and falling enables are bits 31..24, both read/write.
- R5: An edge whose enable is low leaves its flag clear. Clearing an enable bit does not clear a flag that is already set.
- R6: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. When a new edge and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: I/O register bits 31..24 are read/write output controls for pins 7..0. A control bit of 0 drives `usr_drv_low` high for that pin, and a 1 releases the pin.
- R8: I/O register bits 15..12 read 0, bit 11 reads the memory-size code (0), bits 10..8 read the controller-count code (001), and bits 7..3 read 0x1F. Writes to these bits and to bits 23..16 have no effect.
- R9: I/O register bit 2 reads 0 exactly when some flag is set whose enable is also set. Bits 1..0 read `ctl_irq_n[1:0]`, with bit 1 for controller 2 and bit 0 for controller 1.
- R10: `irq_n` is low exactly when a `ctl_irq_n` bit is low or the bit-2 condition of R9 holds.
- R11: Reset register bit 0 is read/write and drives `ctl_rst_n`, where 0 holds the controllers in reset. Bits 31..1 read 0.
- R12: A write to offset 3 changes no register, and a read of offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| usr_in | input | 8 | Raw user input pins |
| usr_drv_low | output | 8 | Drive-low enable per user output pin |
| ctl_irq_n | input | 2 | Active-low controller interrupts (bit 1 is controller 2) |
| ctl_rst_n | output | 1 | Active-low reset to both controllers |
| irq_n | output | 1 | Merged active-low interrupt |

## Verification
The checker enforces several rules on every cycle:
- The filtered level moves only to the previous synchronised value.
- A flag can rise only if its enable was high.
- A write-one clear leaves the flag low unless an edge arrived in the same cycle.
- The merged interrupt always has a cause, and a controller interrupt always forces it low.
- The pin outputs follow the values written to them.

Three behaviours need the bench's timed scenarios because no single-cycle property captures them: rejection of a 2-cycle glitch against acceptance of a 3-cycle pulse, an edge that lands in the exact cycle of its own clear, and flags that outlive the disabling of their enables.

// File: rtl/dio_pkg.sv
// Package: shared register offsets and field widths for the discrete I/O
// edge interrupt controller. Assumes 32-bit registers and 8 pins per direction.
package dio_pkg;
    localparam int IO_W    = 8;
    localparam int WORD_W  = 32;
    localparam int OFS_W   = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_IO     = 2'd0,
        OFS_EDGE   = 2'd1,
        OFS_CTLRST = 2'd2,
        OFS_NONE   = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/dio_in_filter.sv
// Module: per-pin synchroniser, glitch filter and edge pulse generator.
// The filtered level follows the synchronised level once it has differed
// for FILT_CYC consecutive cycles. A one-cycle rise or fall pulse comes out
// at the same edge. Assumes SYNC_STAGES >= 2 and FILT_CYC >= 1.
module dio_in_filter #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_lvl,
    output logic [W-1:0] flt_lvl,
    output logic [W-1:0] rise_evt,
    output logic [W-1:0] fall_evt
);
    localparam int CNT_W   = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam int CNT_MAX = FILT_CYC - 1;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [SYNC_STAGES-1:0] sh_q;
        logic [CNT_W-1:0]       cnt_q;
        logic                   lvl_q;
        logic                   rise_q;
        logic                   fall_q;
        logic                   s_now;

        assign s_now = sh_q[SYNC_STAGES-1];

        // Shift the raw pin through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], raw_in[i]};
        end

        // Count cycles of disagreement and accept the level after FILT_CYC of them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                lvl_q  <= 1'b0;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else if (s_now == lvl_q) begin
                cnt_q  <= '0;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end else if (cnt_q == CNT_W'(CNT_MAX)) begin
                cnt_q  <= '0;
                lvl_q  <= s_now;
                rise_q <= s_now;
                fall_q <= ~s_now;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
            end
        end

        assign sync_lvl[i] = s_now;
        assign flt_lvl[i]  = lvl_q;
        assign rise_evt[i] = rise_q;
        assign fall_evt[i] = fall_q;
    end
endmodule

// File: rtl/dio_edge_flags.sv
// Module: edge enables and sticky write-one-to-clear edge flags.
// An edge sets its flag only while the enable held before the write is high.
// A set in the same cycle as a clear wins. Assumes wr_en is already decoded.
module dio_edge_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_fall_en,
    input  logic [W-1:0] wr_rise_en,
    input  logic [W-1:0] wr_fall_clr,
    input  logic [W-1:0] wr_rise_clr,
    input  logic [W-1:0] rise_evt,
    input  logic [W-1:0] fall_evt,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic [W-1:0] rise_st,
    output logic [W-1:0] fall_st,
    output logic         usr_irq
);
    logic [W-1:0] rise_clr;
    logic [W-1:0] fall_clr;

    // Clear masks apply only during a write to this register.
    always_comb begin
        rise_clr = wr_en ? wr_rise_clr : '0;
        fall_clr = wr_en ? wr_fall_clr : '0;
    end

    // Hold the enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
        end else if (wr_en) begin
            rise_en <= wr_rise_en;
            fall_en <= wr_fall_en;
        end
    end

    // Update the sticky flags; an enabled new edge overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_st <= '0;
            fall_st <= '0;
        end else begin
            rise_st <= (rise_st & ~rise_clr) | (rise_evt & rise_en);
            fall_st <= (fall_st & ~fall_clr) | (fall_evt & fall_en);
        end
    end

    // Summarise the flags whose enable is set.
    assign usr_irq = |((rise_st & rise_en) | (fall_st & fall_en));
endmodule

// File: rtl/dio_edge_irq_ctrl.sv
// Module: top of the discrete I/O edge interrupt controller.
// Decodes the register port, holds the output and controller-reset controls,
// builds the read words and merges the interrupts. Assumes ctl_irq_n is
// already synchronous to clk.
module dio_edge_irq_ctrl
    import dio_pkg::*;
#(
    parameter int         SYNC_STAGES  = 2,
    parameter int         FILT_CYC     = 3,
    parameter logic       MEM_SMALL    = 1'b0,
    parameter logic [2:0] CTL_CNT_CODE = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [IO_W-1:0]   usr_in,
    output logic [IO_W-1:0]   usr_drv_low,
    input  logic [1:0]        ctl_irq_n,
    output logic              ctl_rst_n,
    output logic              irq_n
);
    localparam int          HI_LSB   = WORD_W - IO_W;
    localparam int          MID_LSB  = HI_LSB - IO_W;
    localparam logic [4:0]  ONES_FLD = 5'h1F;

    reg_ofs_e          ofs;
    logic              wr_io;
    logic              wr_edge;
    logic              wr_rst;
    logic [IO_W-1:0]   out_q;
    logic              rst_q;
    logic [IO_W-1:0]   sync_lvl;
    logic [IO_W-1:0]   flt_lvl;
    logic [IO_W-1:0]   rise_evt;
    logic [IO_W-1:0]   fall_evt;
    logic [IO_W-1:0]   rise_en;
    logic [IO_W-1:0]   fall_en;
    logic [IO_W-1:0]   rise_st;
    logic [IO_W-1:0]   fall_st;
    logic              usr_irq;
    logic [WORD_W-1:0] io_word;
    logic [WORD_W-1:0] edge_word;
    logic [WORD_W-1:0] rst_word;

    // Decode the offset into per-register write strobes.
    always_comb begin
        ofs     = reg_ofs_e'(bus_addr);
        wr_io   = bus_sel && bus_we && (ofs == OFS_IO);
        wr_edge = bus_sel && bus_we && (ofs == OFS_EDGE);
        wr_rst  = bus_sel && bus_we && (ofs == OFS_CTLRST);
    end

    dio_in_filter #(
        .W           (IO_W),
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYC    (FILT_CYC)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (usr_in),
        .sync_lvl (sync_lvl),
        .flt_lvl  (flt_lvl),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    dio_edge_flags #(
        .W (IO_W)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_edge),
        .wr_fall_en  (bus_wdata[HI_LSB +: IO_W]),
        .wr_rise_en  (bus_wdata[MID_LSB +: IO_W]),
        .wr_fall_clr (bus_wdata[IO_W +: IO_W]),
        .wr_rise_clr (bus_wdata[0 +: IO_W]),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .rise_en     (rise_en),
        .fall_en     (fall_en),
        .rise_st     (rise_st),
        .fall_st     (fall_st),
        .usr_irq     (usr_irq)
    );

    // Hold the output controls (1 = released) and the controller reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            rst_q <= 1'b1;
        end else begin
            if (wr_io)  out_q <= bus_wdata[HI_LSB +: IO_W];
            if (wr_rst) rst_q <= bus_wdata[0];
        end
    end

    // Assemble the three read words.
    always_comb begin
        io_word   = {out_q, flt_lvl, 4'h0, MEM_SMALL, CTL_CNT_CODE,
                     ONES_FLD, ~usr_irq, ctl_irq_n};
        edge_word = {fall_en, rise_en, fall_st, rise_st};
        rst_word  = {{(WORD_W-1){1'b0}}, rst_q};
    end

    // Select the read data by offset.
    always_comb begin
        unique case (ofs)
            OFS_IO:     bus_rdata = io_word;
            OFS_EDGE:   bus_rdata = edge_word;
            OFS_CTLRST: bus_rdata = rst_word;
            default:    bus_rdata = '0;
        endcase
    end

    assign usr_drv_low = ~out_q;
    assign ctl_rst_n   = rst_q;
    assign irq_n       = (&ctl_irq_n) & ~usr_irq;
endmodule

// File: rtl/dio_edge_irq_ctrl_chk.sv
// Module: assertion checker for dio_edge_irq_ctrl, attached by bind.
// Assumes the register offsets of dio_pkg and an 8-bit pin width.
module dio_edge_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [7:0]  sync_lvl,
    input logic [7:0]  flt_lvl,
    input logic [7:0]  rise_evt,
    input logic [7:0]  fall_evt,
    input logic [7:0]  rise_en,
    input logic [7:0]  fall_en,
    input logic [7:0]  rise_st,
    input logic [7:0]  fall_st,
    input logic [1:0]  ctl_irq_n,
    input logic        irq_n,
    input logic [7:0]  usr_drv_low,
    input logic        ctl_rst_n
);
    AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flt_lvl ^ $past(flt_lvl)) & (flt_lvl ^ $past(sync_lvl))) == 8'h00)); // R2
    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == 8'h00)); // R5
    AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fall_st & ~$past(fall_st) & ~$past(fall_en)) == 8'h00)); // R5
    AST_W1C_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd1) |=>
        ((rise_st & $past(bus_wdata[7:0]) & ~$past(rise_evt & rise_en)) == 8'h00)); // R6
    AST_W1C_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd1) |=>
        ((fall_st & $past(bus_wdata[15:8]) & ~$past(fall_evt & fall_en)) == 8'h00)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise_evt & rise_en) & ~rise_st) == 8'h00)); // R6
    AST_CTL_IRQ_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq_n != 2'b11) |-> !irq_n); // R10
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((ctl_irq_n != 2'b11) || (((rise_st & rise_en) | (fall_st & fall_en)) != 8'h00))); // R10
    AST_DRV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd0) |=> (usr_drv_low == ~$past(bus_wdata[31:24]))); // R7
    AST_CTLRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd2) |=> (ctl_rst_n == $past(bus_wdata[0]))); // R11
endmodule

bind dio_edge_irq_ctrl dio_edge_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .sync_lvl    (sync_lvl),
    .flt_lvl     (flt_lvl),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .rise_en     (rise_en),
    .fall_en     (fall_en),
    .rise_st     (rise_st),
    .fall_st     (fall_st),
    .ctl_irq_n   (ctl_irq_n),
    .irq_n       (irq_n),
    .usr_drv_low (usr_drv_low),
    .ctl_rst_n   (ctl_rst_n)
);

// File: tb/dio_edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expectations, and a monitor compares
// them against the design at the falling clock edge.
module dio_edge_irq_ctrl_tb;
    typedef struct {
        int          kind;   // 0 rdata, 1 irq_n, 2 usr_drv_low, 3 ctl_rst_n
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [7:0]  usr_in = 8'h00;
    logic [7:0]  usr_drv_low;
    logic [1:0]  ctl_irq_n = 2'b11;
    logic        ctl_rst_n;
    logic        irq_n;

    exp_t        sb_q[$];
    logic        chk_req = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dio_edge_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .usr_in      (usr_in),
        .usr_drv_low (usr_drv_low),
        .ctl_irq_n   (ctl_irq_n),
        .ctl_rst_n   (ctl_rst_n),
        .irq_n       (irq_n)
    );

    // Monitor: compare the queued expectation against the design outputs.
    always @(negedge clk) begin
        if (chk_req && sb_q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = sb_q.pop_front();
            case (e.kind)
                0:       act = bus_rdata;
                1:       act = {31'h0, irq_n};
                2:       act = {24'h0, usr_drv_low};
                default: act = {31'h0, ctl_rst_n};
            endcase
            n_run++;
            if (act !== e.exp) begin
                n_fail++;
                $display("FAIL %s: actual %08h expected %08h", e.tag, act, e.exp);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [1:0] a,
                               input logic [31:0] e, input string tag);
        exp_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        @(posedge clk); #1;
        bus_addr = a;
        sb_q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic pin_chk(input int kind, input logic [31:0] e, input string tag);
        expect_item(kind, 2'd0, e, tag);
    endtask

    task automatic set_in(input logic [7:0] v);
        @(posedge clk); #1;
        usr_in = v;
        repeat (8) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R8: reset state and constant fields
        read_chk(2'd0, 32'hFF0001FF, "R1 R8 io reset");
        read_chk(2'd1, 32'h00000000, "R1 edge reset");
        read_chk(2'd2, 32'h00000001, "R1 R11 ctlrst reset");
        pin_chk(1, 32'h1, "R1 irq_n reset");
        pin_chk(2, 32'h00, "R1 drv_low reset");
        pin_chk(3, 32'h1, "R1 ctl_rst_n reset");

        // R7 / R8: output controls; read-only fields ignore the write
        bus_write(2'd0, 32'h5A123456);
        read_chk(2'd0, 32'h5A0001FF, "R7 R8 io after write");
        pin_chk(2, 32'hA5, "R7 drv_low pattern");

        // R4: enables are read/write
        bus_write(2'd1, 32'h800F0000);
        read_chk(2'd1, 32'h800F0000, "R4 enables");

        // R3 R4 R5 R9 R10: bit0 rise enabled, bit7 rise disabled
        set_in(8'h81);
        read_chk(2'd0, 32'h5A8101FB, "R3 R9 io levels and summary");
        read_chk(2'd1, 32'h800F0001, "R4 R5 rise flags");
        pin_chk(1, 32'h0, "R10 irq from user flag");

        // R4: falling edge on bit7
        set_in(8'h01);
        read_chk(2'd1, 32'h800F8001, "R4 fall flag");

        // R6: write-one clears; zero writes leave flags alone
        bus_write(2'd1, 32'h800F0001);
        read_chk(2'd1, 32'h800F8000, "R6 clear rise");
        bus_write(2'd1, 32'h800F0000);
        read_chk(2'd1, 32'h800F8000, "R6 zero no effect");
        bus_write(2'd1, 32'h800F8000);
        read_chk(2'd1, 32'h800F0000, "R6 clear fall");
        pin_chk(1, 32'h1, "R10 irq released");
        read_chk(2'd0, 32'h5A0101FF, "R9 summary inactive");

        // R5: disabling keeps the flag; the summary follows the enable
        set_in(8'h03);
        read_chk(2'd1, 32'h800F0002, "R4 rise bit1");
        bus_write(2'd1, 32'h00000000);
        read_chk(2'd1, 32'h00000002, "R5 flag kept after disable");
        pin_chk(1, 32'h1, "R10 disabled flag no irq");
        read_chk(2'd0, 32'h5A0301FF, "R9 disabled flag no summary");
        bus_write(2'd1, 32'h000F0000);
        pin_chk(1, 32'h0, "R10 re-enabled flag");
        bus_write(2'd1, 32'h000F0002);
        read_chk(2'd1, 32'h000F0000, "R6 clear bit1");

        // R2: a 2-cycle pulse is rejected
        @(posedge clk); #1 usr_in = 8'h07;
        repeat (2) @(posedge clk);
        #1 usr_in = 8'h03;
        repeat (8) @(posedge clk);
        read_chk(2'd0, 32'h5A0301FF, "R2 glitch level");
        read_chk(2'd1, 32'h000F0000, "R2 glitch no flag");

        // R2: a 3-cycle pulse is accepted
        @(posedge clk); #1 usr_in = 8'h07;
        repeat (3) @(posedge clk);
        #1 usr_in = 8'h03;
        repeat (8) @(posedge clk);
        read_chk(2'd1, 32'h000F0004, "R2 three-cycle pulse");
        bus_write(2'd1, 32'h000F0004);

        // R6: an edge and its clear in the same cycle leave the flag set
        @(posedge clk); #1 usr_in = 8'h0B;
        repeat (5) @(posedge clk);
        #1 bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h000F0008;
        @(posedge clk); #1 bus_sel = 1'b0; bus_we = 1'b0;
        read_chk(2'd1, 32'h000F0008, "R6 set wins over clear");
        bus_write(2'd1, 32'h000F0008);
        read_chk(2'd1, 32'h000F0000, "R6 later clear");

        // R9 R10: controller interrupt
        @(posedge clk); #1 ctl_irq_n = 2'b10;
        read_chk(2'd0, 32'h5A0B01FE, "R9 ctl irq bits");
        pin_chk(1, 32'h0, "R10 ctl irq merges");
        @(posedge clk); #1 ctl_irq_n = 2'b11;
        pin_chk(1, 32'h1, "R10 ctl irq released");

        // R11: controller reset register
        bus_write(2'd2, 32'hFFFFFFFE);
        read_chk(2'd2, 32'h00000000, "R11 reset held");
        pin_chk(3, 32'h0, "R11 ctl_rst_n low");
        bus_write(2'd2, 32'hFFFFFFFF);
        read_chk(2'd2, 32'h00000001, "R11 reset released");
        pin_chk(3, 32'h1, "R11 ctl_rst_n high");

        // R12: unmapped offset
        bus_write(2'd3, 32'hFFFFFFFF);
        read_chk(2'd3, 32'h00000000, "R12 unmapped read");
        read_chk(2'd0, 32'h5A0B01FF, "R12 io unchanged");
        read_chk(2'd1, 32'h000F0000, "R12 edge unchanged");
        read_chk(2'd2, 32'h00000001, "R12 ctlrst unchanged");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule